// File: doc/BRIEF.md
# Transpose Buffer for a Two-Pass 8x8 Transform

This block sits between the row pass and the column pass of a separable two-dimensional 8x8 transform. The row pass delivers 16-bit results of one 8x8 tile in row-major arrival order. The column pass needs the same tile column by column. Both passes stay busy at the same time: the row pass writes tile N+1 into the same 64-word store while the column pass drains tile N.

A second bank is not needed. The index-to-address map flips between straight order and swapped order on every tile. Each new tile therefore lands at the addresses in the order that the previous tile is being read. A word is replaced only in the cycle it is read, or after that cycle. In a cycle where the same address is both read and written, the read returns the old word. The write side is held back whenever it would get ahead of the reader inside the tile.

The read side presents a word with a valid flag and waits for ready. The write side takes a word when its valid and ready are both high. Each side has a flag that marks the first word of a tile.

Top module: `transpose_buffer`

## Requirements
- R1: After reset, rd_valid is 0, wr_ready is 1 and wr_first is 1.
- R2: A word is taken when wr_valid and wr_ready are both 1. The k-th word taken in a tile (k = 0..63) is the element at row k/8, column k%8.
- R3: rd_valid rises only in the cycle after the 64th word of a tile is taken. No word of a tile is offered before the whole tile has been written.
- R4: The j-th word read from a tile (j = 0..63, counting handshakes where rd_valid and rd_ready are both 1) is the element at row j%8, column j/8. That element is the word written at index (j%8)*8 + j/8.
- R5: R4 holds for every tile in an unbroken stream. The alternating address order has no effect that can be seen at the ports.
- R6: While rd_valid is 1 and rd_ready is 0, rd_data and rd_valid hold their values into the next cycle.
- R7: While a tile is waiting or being read, wr_ready is 1 only in two cases. Either fewer words of the next tile have been taken than words of the current tile have been read, or the two counts are equal and rd_ready is 1 in that cycle.
- R8: When a read and a write reach the same storage location in the same cycle, the read returns the word that was there before the write. A new tile can then follow the draining one with no gap.
- R9: While no complete tile is pending, wr_ready is 1.
- R10: wr_first is 1 when the next word taken starts a tile. rd_first is 1 exactly when rd_valid is 1 and the word on offer is word 0 of its tile.
- R11: After the last word of a tile is read, rd_valid is 0 in the next cycle unless another tile completed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Row pass offers a word |
| wr_data | input | 16 | Word from the row pass |
| wr_ready | output | 1 | Buffer takes the offered word this cycle |
| wr_first | output | 1 | Next word taken starts a tile |
| rd_ready | input | 1 | Column pass takes the offered word |
| rd_valid | output | 1 | A word of a complete tile is on offer |
| rd_data | output | 16 | Word to the column pass, in transposed order |
| rd_first | output | 1 | Word on offer is the first of its tile |

## Verification
The bench runs many tiles back to back, so that both address orders are used repeatedly. A design that never flips the order, or flips it on only one side, produces an untransposed tile or overwrites words that have not been read yet. Full-rate streaming makes the write hit the read address on every cycle of the tile overlap. A design that returns the new word there, or whose writer races ahead, puts the next tile's data in the output. Phases with a slow reader and phases with a slow writer check that back-pressure stops at the reader's exact position, that wr_ready stays high while nothing is pending, and that a stalled output word does not change. Throughout, the boundary flags are checked against tile word 0 on both sides.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
    // Order in which a linear tile index maps onto storage.
    typedef enum logic {
        ORD_STRAIGHT = 1'b0,   // address = index
        ORD_SWAPPED  = 1'b1    // address = index with row/column halves exchanged
    } order_e;
endpackage

// File: rtl/tbuf_addr_map.sv
module tbuf_addr_map
    import tbuf_pkg::*;
#(
    parameter int DIM = 8,
    localparam int NWORDS = DIM * DIM,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic [AW-1:0] idx,
    input  order_e        ord,
    output logic [AW-1:0] addr
);
    localparam int HW = $clog2(DIM);

    logic [AW-1:0] swapped;

    generate
        if ((1 << HW) == DIM) begin : g_pow2
            // Exchanging the two index halves is a pure rewiring.
            assign swapped = {idx[HW-1:0], idx[AW-1:HW]};
        end else begin : g_generic
            always_comb begin
                int unsigned r;
                int unsigned c;
                r = int'(idx) / DIM;
                c = int'(idx) % DIM;
                swapped = AW'(c * DIM + r);
            end
        end
    endgenerate

    assign addr = (ord == ORD_SWAPPED) ? swapped : idx;
endmodule

// File: rtl/tbuf_store.sv
module tbuf_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // The read is combinational from the current contents, so a write to the
    // same location lands only at the edge: the reader sees the old word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl
    import tbuf_pkg::*;
#(
    parameter int DIM = 8,
    localparam int NWORDS = DIM * DIM,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_ready,
    output logic          wr_ready,
    output logic          wr_fire,
    output logic          rd_valid,
    output logic          rd_fire,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output order_e        wr_ord,
    output order_e        rd_ord,
    output logic          wr_first,
    output logic          rd_first
);
    localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

    typedef struct packed {
        logic [AW-1:0] wr_idx;
        order_e        wr_ord;
        logic [AW-1:0] rd_idx;
        order_e        rd_ord;
        logic          pending;   // a complete tile is waiting or being read
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  wr_done, rd_done;

    always_comb begin
        st_d = st_q;

        rd_valid = st_q.pending;
        rd_fire  = rd_valid && rd_ready;
        // The writer follows the reader through the same address sequence.
        wr_ready = !st_q.pending
                || (st_q.wr_idx < st_q.rd_idx)
                || ((st_q.wr_idx == st_q.rd_idx) && rd_ready);
        wr_fire  = wr_valid && wr_ready;

        rd_done = rd_fire && (st_q.rd_idx == LAST);
        wr_done = wr_fire && (st_q.wr_idx == LAST);

        if (rd_fire) begin
            st_d.rd_idx = rd_done ? '0 : st_q.rd_idx + 1'b1;
            if (rd_done) begin
                st_d.rd_ord = order_e'(~st_q.rd_ord);
            end
        end
        if (wr_fire) begin
            st_d.wr_idx = wr_done ? '0 : st_q.wr_idx + 1'b1;
            if (wr_done) begin
                st_d.wr_ord = order_e'(~st_q.wr_ord);
            end
        end

        if (wr_done) begin
            st_d.pending = 1'b1;
        end else if (rd_done) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_idx  <= '0;
            st_q.wr_ord  <= ORD_STRAIGHT;
            st_q.rd_idx  <= '0;
            st_q.rd_ord  <= ORD_SWAPPED;
            st_q.pending <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx   = st_q.wr_idx;
    assign rd_idx   = st_q.rd_idx;
    assign wr_ord   = st_q.wr_ord;
    assign rd_ord   = st_q.rd_ord;
    assign wr_first = (st_q.wr_idx == '0);
    assign rd_first = st_q.pending && (st_q.rd_idx == '0);

    // R7: while a tile is held, the writer never stands ahead of the reader.
    a_r7_writer_behind: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> (st_q.wr_idx <= st_q.rd_idx));

    // R3: reading opens only right after the final word of a tile was taken.
    a_r3_full_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($past(wr_fire) && ($past(st_q.wr_idx) == LAST)));

    // R11: last word read with no tile completing closes the read side.
    a_r11_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && (st_q.rd_idx == LAST) && !(wr_fire && (st_q.wr_idx == LAST)))
        |=> !rd_valid);

    // R5: the two sides use opposite orders only while no tile is held.
    a_r5_order_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pending |-> (st_q.wr_ord != st_q.rd_ord));
endmodule

// File: rtl/transpose_buffer.sv
module transpose_buffer
    import tbuf_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIM   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_first,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_first
);
    localparam int NWORDS = DIM * DIM;
    localparam int AW     = $clog2(NWORDS);

    logic          wr_fire, rd_fire;
    logic [AW-1:0] wr_idx, rd_idx, wr_addr, rd_addr;
    order_e        wr_ord, rd_ord;

    tbuf_ctrl #(.DIM(DIM)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_ready (rd_ready),
        .wr_ready (wr_ready),
        .wr_fire  (wr_fire),
        .rd_valid (rd_valid),
        .rd_fire  (rd_fire),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .wr_ord   (wr_ord),
        .rd_ord   (rd_ord),
        .wr_first (wr_first),
        .rd_first (rd_first)
    );

    tbuf_addr_map #(.DIM(DIM)) u_wmap (
        .idx  (wr_idx),
        .ord  (wr_ord),
        .addr (wr_addr)
    );

    tbuf_addr_map #(.DIM(DIM)) u_rmap (
        .idx  (rd_idx),
        .ord  (rd_ord),
        .addr (rd_addr)
    );

    tbuf_store #(.WIDTH(WIDTH), .DEPTH(NWORDS)) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R6: a stalled offer stays put.
    a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10: the read-side tile marker only accompanies a valid word.
    a_r10_first_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_first |-> rd_valid);

    // R8: a word handed over at the reader's spot does not disturb the offer.
    a_r8_old_word_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && wr_fire) |=> $stable(rd_data));
endmodule

// File: tb/transpose_buffer_test.sv
module transpose_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int D = 8;
    localparam int N = D * D;
    localparam int WATCHDOG = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_ready = 1'b0;
    logic         wr_ready, wr_first, rd_valid, rd_first;
    logic [W-1:0] rd_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    transpose_buffer #(.WIDTH(W), .DIM(D)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .wr_first (wr_first),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_first (rd_first)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: a filling tile and a draining tile, kept apart.
    int wtile [N];
    int rtile [N];
    int wcnt = 0;
    int rcnt = 0;
    bit rfull = 1'b0;
    int tiles_read = 0;
    bit stalled_prev = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_phase(input int cycles, input int wr_pct, input int rd_pct);
        for (int n = 0; n < cycles; n++) begin
            bit exp_wready, wfire, rfire;
            int exp_word;
            @(negedge clk);
            wr_valid = (($urandom % 100) < wr_pct);
            wr_data  = W'($urandom);
            rd_ready = (($urandom % 100) < rd_pct);
            #1;
            exp_wready = !rfull || (wcnt < rcnt) || ((wcnt == rcnt) && rd_ready);
            check(rfull ? "R7 wr_ready under back-pressure" : "R9 wr_ready while idle",
                  int'(wr_ready), int'(exp_wready));
            check("R3 R11 rd_valid", int'(rd_valid), int'(rfull));
            check("R10 wr_first", int'(wr_first), int'(wcnt == 0));
            check("R10 rd_first", int'(rd_first), int'(rfull && rcnt == 0));
            if (rfull) begin
                exp_word = rtile[(rcnt % D) * D + rcnt / D];
                check(stalled_prev ? "R6 held word" : "R2 R4 R5 R8 transposed word",
                      int'(rd_data), exp_word);
            end
            wfire = wr_valid && exp_wready;
            rfire = rfull && rd_ready;
            stalled_prev = rfull && !rd_ready;
            @(posedge clk);
            if (rfire) begin
                rcnt++;
                if (rcnt == N) begin
                    rcnt = 0;
                    rfull = 1'b0;
                    tiles_read++;
                end
            end
            if (wfire) begin
                wtile[wcnt] = int'(wr_data);
                wcnt++;
                if (wcnt == N) begin
                    wcnt = 0;
                    rtile = wtile;
                    rfull = 1'b1;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 wr_ready in reset", int'(wr_ready), 1);
        check("R1 rd_valid in reset", int'(rd_valid), 0);
        check("R1 wr_first in reset", int'(wr_first), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_valid after reset", int'(rd_valid), 0);

        run_phase(450, 100, 100);   // both sides at full rate: R8 overlap
        run_phase(2000, 90, 35);    // slow reader: R7 stops, R6 holds
        run_phase(2000, 30, 95);    // slow writer: R9, R11 gaps
        run_phase(1500, 70, 70);    // mixed
        run_phase(200, 0, 100);     // drain

        check("R5 tiles transposed in sequence", int'(tiles_read >= 12), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1-side run hung actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule